// File: doc/BRIEF.md
# Shared-Counter Compare Timer Interrupt

This block keeps one free-running 32-bit counter that several cores share, and gives each core its own compare register, timer pending flag, local mask and pin-routing register. When the counter value equals a core's compare value on a cycle where the counter advances, that core's pending flag sets. If the core's mask enables the timer source and the routing register has its route flag set, the pending flag drives one of the core's interrupt pins, chosen by the routing register's pin field.

Software reaches the block over a simple 32-bit register bus: a write strobe, a word address, write data, and a core-select input. The core-select input picks which core's per-core registers an access reaches; the read data is combinational from the address and select. A stop bit in the shared configuration word freezes the counter, and the counter can only be loaded while it is frozen. Rewriting a core's compare value acknowledges that core's timer interrupt.

Top module: `tmr_cmp_irq`

Word addresses: 0 config (bit 0 = stop), 1 counter, 2 counter upper (reads 0), 4 mask (read), 5 mask set, 6 mask clear, 7 pending (bit 1 = timer pending), 8 pin route (bit 31 = route flag, bits 5:0 = pin), 9 compare, 10 compare upper (reads 0).

## Requirements
- R1: Writing address 0 with bit 0 = 1 freezes the counter and with bit 0 = 0 lets it advance by one per cycle; reading address 0 returns the stop state in bit 0.
- R2: A write to address 1 loads the counter only while it is frozen; while the counter runs the write has no effect on the counter value.
- R3: Addresses 2 and 10 always read zero.
- R4: On a cycle where the counter advances and equals a core's compare value, that core's pending bit (address 7, bit 1) sets and stays set until that core's compare register is written.
- R5: Output bit c*NUM_PINS+p is 1 exactly when core c is pending, its mask bit 1 is 1, its route flag (bit 31) is 1 and its pin field equals p; at most one pin per core is active.
- R6: Writing a core's compare register (address 9) stores the value and clears that core's pending bit, taking priority over a match in the same cycle, so its pin drops.
- R7: Writing address 5 sets the mask bits written as 1, writing address 6 clears them, and address 4 returns the 6-bit mask; writes to address 4 have no effect.
- R8: A route write (address 8) whose pin field (bits 5:0) exceeds NUM_PINS-1 is rejected and the route register keeps its previous value; a legal write stores bit 31 and bits 5:0.
- R9: After reset the counter is 0 and running, and for every core the compare value is 0xFFFFFFFF, pending is 0, the mask is 0x32 and the route register is 0x80000000 (flag set, pin 0); all interrupt outputs are 0.
- R10: Per-core accesses reach only the core named by the core-select input; other cores' registers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_core_i | input | CORE_W | Core selected for per-core registers |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current address and core |
| irq_o | output | NUM_CORES*NUM_PINS | Interrupt pins, NUM_PINS per core |

## Verification
The hardest state to reach is a timer match at a known cycle, because the counter runs from reset and the reset compare value is far out of reach. The stimulus freezes the counter, loads a value just below a chosen compare value, programs the compare while frozen, and then releases the stop bit so the match lands a few cycles later. The pending flag is then walked through mask, route-flag and pin-field changes before a compare rewrite acknowledges it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned REG_CFG      = 0;
  localparam int unsigned REG_CNT_LO   = 1;
  localparam int unsigned REG_CNT_HI   = 2;
  localparam int unsigned REG_MASK     = 4;
  localparam int unsigned REG_MASK_SET = 5;
  localparam int unsigned REG_MASK_CLR = 6;
  localparam int unsigned REG_PEND     = 7;
  localparam int unsigned REG_ROUTE    = 8;
  localparam int unsigned REG_CMP_LO   = 9;
  localparam int unsigned REG_CMP_HI   = 10;

  localparam int unsigned STOP_BIT     = 0;
  localparam int unsigned TMR_SRC_BIT  = 1;
  localparam int unsigned LMASK_W      = 6;
  localparam logic [LMASK_W-1:0] LMASK_RST = 6'h32;
  localparam int unsigned ROUTE_FLAG_BIT = 31;
  localparam int unsigned ROUTE_PIN_W  = 6;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  assign tick_o = ~stop_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (stop_i && load_i) cnt_q <= load_val_i;
    else if (!stop_i)          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_core_slice.sv
module tmr_core_slice import tmr_pkg::*; #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_PINS = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [DATA_W-1:0]   cnt_i,
  input  logic                cmp_we_i,
  input  logic                mset_we_i,
  input  logic                mclr_we_i,
  input  logic                route_we_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   cmp_o,
  output logic [LMASK_W-1:0]  mask_o,
  output logic                pend_o,
  output logic [DATA_W-1:0]   route_o,
  output logic [NUM_PINS-1:0] irq_o
);
  logic [DATA_W-1:0]      cmp_q;
  logic [LMASK_W-1:0]     mask_q;
  logic                   pend_q;
  logic                   flag_q;
  logic [ROUTE_PIN_W-1:0] pin_q;
  logic [ROUTE_PIN_W-1:0] pin_wr;
  logic                   pin_ok;

  assign pin_wr = wdata_i[ROUTE_PIN_W-1:0];
  assign pin_ok = (int'(pin_wr) <= NUM_PINS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '1;
      mask_q <= LMASK_RST;
      pend_q <= 1'b0;
      flag_q <= 1'b1;
      pin_q  <= '0;
    end else begin
      if (cmp_we_i) cmp_q <= wdata_i;
      // compare write acknowledges; wins over a same-cycle match
      if (cmp_we_i)                     pend_q <= 1'b0;
      else if (tick_i && cnt_i == cmp_q) pend_q <= 1'b1;
      if (mset_we_i)      mask_q <= mask_q | wdata_i[LMASK_W-1:0];
      else if (mclr_we_i) mask_q <= mask_q & ~wdata_i[LMASK_W-1:0];
      if (route_we_i && pin_ok) begin
        flag_q <= wdata_i[ROUTE_FLAG_BIT];
        pin_q  <= pin_wr;
      end
    end
  end

  always_comb begin
    route_o = '0;
    route_o[ROUTE_FLAG_BIT] = flag_q;
    route_o[ROUTE_PIN_W-1:0] = pin_q;
  end

  assign cmp_o  = cmp_q;
  assign mask_o = mask_q;
  assign pend_o = pend_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign irq_o[p] = pend_q & mask_q[TMR_SRC_BIT] & flag_q & (int'(pin_q) == p);
  end
endmodule

// File: rtl/tmr_cmp_irq.sv
module tmr_cmp_irq import tmr_pkg::*; #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_PINS  = 6,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          bus_we_i,
  input  logic [ADDR_W-1:0]             bus_addr_i,
  input  logic [CORE_W-1:0]             bus_core_i,
  input  logic [DATA_W-1:0]             bus_wdata_i,
  output logic [DATA_W-1:0]             bus_rdata_o,
  output logic [NUM_CORES*NUM_PINS-1:0] irq_o
);
  logic              stop_q;
  logic [DATA_W-1:0] cnt_q;
  logic              tick;
  logic              sel_ok;
  logic [NUM_CORES-1:0] pend_v;
  logic [DATA_W-1:0]  cmp_a   [NUM_CORES];
  logic [LMASK_W-1:0] mask_a  [NUM_CORES];
  logic [DATA_W-1:0]  route_a [NUM_CORES];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned r);
    return bus_we_i && (int'(a) == r);
  endfunction

  assign sel_ok = (int'(bus_core_i) < NUM_CORES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      stop_q <= 1'b0;
    else if (hit(bus_addr_i, REG_CFG)) stop_q <= bus_wdata_i[STOP_BIT];
  end

  tmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_i     (stop_q),
    .load_i     (hit(bus_addr_i, REG_CNT_LO)),
    .load_val_i (bus_wdata_i),
    .cnt_o      (cnt_q),
    .tick_o     (tick)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic me;
    assign me = sel_ok && (int'(bus_core_i) == c);
    tmr_core_slice #(.DATA_W(DATA_W), .NUM_PINS(NUM_PINS)) u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .cnt_i      (cnt_q),
      .cmp_we_i   (me && hit(bus_addr_i, REG_CMP_LO)),
      .mset_we_i  (me && hit(bus_addr_i, REG_MASK_SET)),
      .mclr_we_i  (me && hit(bus_addr_i, REG_MASK_CLR)),
      .route_we_i (me && hit(bus_addr_i, REG_ROUTE)),
      .wdata_i    (bus_wdata_i),
      .cmp_o      (cmp_a[c]),
      .mask_o     (mask_a[c]),
      .pend_o     (pend_v[c]),
      .route_o    (route_a[c]),
      .irq_o      (irq_o[c*NUM_PINS +: NUM_PINS])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    case (int'(bus_addr_i))
      REG_CFG:    bus_rdata_o[STOP_BIT] = stop_q;
      REG_CNT_LO: bus_rdata_o = cnt_q;
      REG_MASK:   if (sel_ok) bus_rdata_o[LMASK_W-1:0] = mask_a[bus_core_i];
      REG_PEND:   if (sel_ok) bus_rdata_o[TMR_SRC_BIT] = pend_v[bus_core_i];
      REG_ROUTE:  if (sel_ok) bus_rdata_o = route_a[bus_core_i];
      REG_CMP_LO: if (sel_ok) bus_rdata_o = cmp_a[bus_core_i];
      default:    bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_cmp_irq_chk.sv
module tmr_cmp_irq_chk import tmr_pkg::*; #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned NUM_PINS  = 6,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CORE_W    = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          bus_we_i,
  input logic [ADDR_W-1:0]             bus_addr_i,
  input logic [CORE_W-1:0]             bus_core_i,
  input logic [DATA_W-1:0]             bus_rdata_i,
  input logic [DATA_W-1:0]             cnt_i,
  input logic                          stop_i,
  input logic [NUM_CORES-1:0]          pend_i,
  input logic [NUM_CORES*NUM_PINS-1:0] irq_i
);
  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !(bus_we_i && int'(bus_addr_i) == REG_CNT_LO) |=> $stable(cnt_i)); // R1
  AST_CNT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |=> cnt_i == $past(cnt_i) + 1); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(bus_addr_i) == REG_CNT_HI || int'(bus_addr_i) == REG_CMP_HI) |-> bus_rdata_i == '0); // R3

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    logic cmp_wr;
    assign cmp_wr = bus_we_i && int'(bus_addr_i) == REG_CMP_LO && int'(bus_core_i) == c;
    AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_i[c] && !cmp_wr |=> pend_i[c]); // R4
    AST_PIN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(irq_i[c*NUM_PINS +: NUM_PINS])); // R5
    AST_PIN_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|irq_i[c*NUM_PINS +: NUM_PINS]) |-> pend_i[c]); // R5
    AST_CMP_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_wr |=> !pend_i[c]); // R6
  end
endmodule

bind tmr_cmp_irq tmr_cmp_irq_chk #(
  .NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS), .DATA_W(DATA_W),
  .ADDR_W(ADDR_W), .CORE_W(CORE_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_core_i  (bus_core_i),
  .bus_rdata_i (bus_rdata_o),
  .cnt_i       (cnt_q),
  .stop_i      (stop_q),
  .pend_i      (pend_v),
  .irq_i       (irq_o)
);

// File: tb/tb_tmr_cmp_irq.sv
module tb_tmr_cmp_irq;
  localparam int NC = 4;
  localparam int NP = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [3:0]    addr = '0;
  logic [1:0]    sel = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NC*NP-1:0] irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_cmp_irq dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_core_i(sel), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic        w;
    logic [1:0]  c;
    logic [3:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 4'd0,  32'h1,         32'h0,         4'd1},  // R1 freeze
    '{1'b0, 2'd0, 4'd0,  32'h0,         32'h1,         4'd1},  // R1 stop readback
    '{1'b1, 2'd0, 4'd1,  32'h100,       32'h0,         4'd2},  // R2 load while frozen
    '{1'b0, 2'd0, 4'd1,  32'h0,         32'h100,       4'd2},
    '{1'b0, 2'd0, 4'd2,  32'h0,         32'h0,         4'd3},  // R3
    '{1'b0, 2'd1, 4'd10, 32'h0,         32'h0,         4'd3},  // R3
    '{1'b1, 2'd1, 4'd9,  32'hFFFF0055,  32'h0,         4'd10}, // R10
    '{1'b0, 2'd1, 4'd9,  32'h0,         32'hFFFF0055,  4'd10},
    '{1'b0, 2'd0, 4'd9,  32'h0,         32'hFFFFFFFF,  4'd10},
    '{1'b1, 2'd2, 4'd5,  32'h01,        32'h0,         4'd7},  // R7 set
    '{1'b0, 2'd2, 4'd4,  32'h0,         32'h33,        4'd7},
    '{1'b1, 2'd2, 4'd6,  32'h30,        32'h0,         4'd7},  // R7 clear
    '{1'b1, 2'd2, 4'd4,  32'h3F,        32'h0,         4'd7},  // R7 write to read location
    '{1'b0, 2'd2, 4'd4,  32'h0,         32'h03,        4'd7},
    '{1'b1, 2'd3, 4'd8,  32'h80000003,  32'h0,         4'd8},  // R8 legal
    '{1'b1, 2'd3, 4'd8,  32'h00000007,  32'h0,         4'd8},  // R8 pin 7 rejected
    '{1'b0, 2'd3, 4'd8,  32'h0,         32'h80000003,  4'd8}
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] c, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = c; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] c, input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    we = 1'b0; sel = c; addr = a;
    #1 v = rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    chk(9, {8'h0, irq}, 32'h0);
    rd(0, 4'd0, v);  chk(9, v, 32'h0);
    for (int c = 0; c < NC; c++) begin
      rd(2'(c), 4'd9, v); chk(9, v, 32'hFFFFFFFF);
      rd(2'(c), 4'd4, v); chk(9, v, 32'h32);
      rd(2'(c), 4'd8, v); chk(9, v, 32'h80000000);
      rd(2'(c), 4'd7, v); chk(9, v, 32'h0);
    end
    rd(0, 4'd1, v); rd(0, 4'd1, v2);
    chk(9, v2 - v, 32'd1); // R9 counter running after reset

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].w) wr(VECS[i].c, VECS[i].a, VECS[i].d);
      else begin
        rd(VECS[i].c, VECS[i].a, v);
        chk(int'(VECS[i].r), v, VECS[i].e);
      end
    end

    // R1 frozen counter holds
    rd(0, 4'd1, v); repeat (5) @(negedge clk); rd(0, 4'd1, v2);
    chk(1, v2, v);

    // R4 match: counter 0x10, core0 compare 0x14
    wr(0, 4'd1, 32'h10);
    wr(0, 4'd9, 32'h14);
    wr(0, 4'd0, 32'h0);
    rd(0, 4'd0, v); chk(1, v, 32'h0);
    rd(0, 4'd7, v); chk(4, v, 32'h0);
    repeat (8) @(negedge clk);
    rd(0, 4'd7, v); chk(4, v, 32'h2);
    rd(1, 4'd7, v); chk(10, v, 32'h0);
    repeat (4) @(negedge clk);
    rd(0, 4'd7, v); chk(4, v, 32'h2); // R4 sticky
    chk(5, {8'h0, irq}, 32'h1);

    // R5 mask, route pin and flag
    wr(0, 4'd6, 32'h02); #1 chk(5, {8'h0, irq}, 32'h0);
    rd(0, 4'd7, v); chk(7, v, 32'h2);
    wr(0, 4'd5, 32'h02); #1 chk(5, {8'h0, irq}, 32'h1);
    wr(0, 4'd8, 32'h80000004); #1 chk(5, {8'h0, irq}, 32'h10);
    wr(0, 4'd8, 32'h00000004); #1 chk(5, {8'h0, irq}, 32'h0);
    wr(0, 4'd8, 32'h80000004); #1 chk(5, {8'h0, irq}, 32'h10);

    // R6 compare write acknowledges
    wr(0, 4'd9, 32'hFFFF0000);
    #1 chk(6, {8'h0, irq}, 32'h0);
    rd(0, 4'd7, v); chk(6, v, 32'h0);
    rd(0, 4'd9, v); chk(6, v, 32'hFFFF0000);

    // R2 load ignored while running
    wr(0, 4'd1, 32'hABCD0000);
    rd(0, 4'd1, v); chk(2, {16'h0, v[31:16]}, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule